// File: doc/BRIEF.md
# Power-State Sequencer

This block sequences the power states of a wireless system-on-chip. It moves between five states: Off, Deep-sleep, Sleep, Wakeup and On. From each state it derives the enables for the always-on RTC domain, the main power domain, the crystal oscillator and the PLL. It also gates the high-speed clock of each functional block, and the CPU clock on its own, while the chip is On.

Control comes from four places:
- The chip-enable pin is asynchronous. It is brought into the block's clock domain through a two-flop synchronizer.
- A sleep request chooses between light sleep and deep sleep.
- Four wake sources bring the chip back: MAC, host, RTC timer and external interrupt.
- A 16-bit settle value holds the chip in Wakeup until the crystal is stable.

Light sleep keeps the main domain powered and stops the oscillator. Deep sleep leaves only the RTC domain alive, and only the RTC timer (or a chip-enable cycle) can end it.

Top module: `pwr_seq_top`

## Requirements
- R1: While the synchronized chip enable is low, the state returns to Off on the next clock edge. In Off, every output is low, the RTC enable included. The pin reaches the state logic through two flops, so a falling pin gives Off on the third clock edge.
- R2: From Off, a high pin moves the state to Wakeup on the third clock edge after the pin rises. Before that edge the state stays Off.
- R3: In Wakeup, the RTC, main, crystal and PLL enables are all high. Wakeup lasts max(settle_cfg, 1) cycles, then the state becomes On. settle_cfg is sampled on the edge that enters Wakeup.
- R4: In On, all four enables are high and blk_clk_en[i] equals clk_ctrl[i]. In every other state, blk_clk_en is all zero.
- R5: While On, wfi_req gates the CPU clock from the next cycle (cpu_clk_en low). cpu_irq ungates it from the next cycle and wins when both are high. Each entry into On starts with the CPU clock running.
- R6: In On, sleep_req with deep_sel low moves the state to Sleep. In Sleep, rtc_en and main_pwr_en are high, xtal_en and pll_en are low, and no clock enable is high.
- R7: In On, sleep_req with deep_sel high moves the state to Deep-sleep. In Deep-sleep, only rtc_en is high.
- R8: In Sleep, any of wake_mac, wake_host, wake_rtc or wake_ext moves the state to Wakeup on the next edge. With no wake, the state stays Sleep.
- R9: In Deep-sleep, wake_mac, wake_host and wake_ext are ignored. Only wake_rtc moves the state to Wakeup.
- R10: A wake that is high in the same cycle as the sleep request is kept. The state spends one cycle in Sleep (or in Deep-sleep, when the wake is wake_rtc) and then goes to Wakeup.
- R11: state_o encodes the state as Off=0, Deep-sleep=1, Sleep=2, Wakeup=3, On=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (RTC domain) |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_pin | input | 1 | Asynchronous chip-enable pin |
| sleep_req | input | 1 | Sleep criteria met (acted on in On) |
| deep_sel | input | 1 | Selects Deep-sleep instead of Sleep |
| wake_mac | input | 1 | Wake event from the MAC |
| wake_host | input | 1 | Wake event from the host |
| wake_rtc | input | 1 | Wake event from the RTC timer |
| wake_ext | input | 1 | Wake event from an external interrupt |
| settle_cfg | input | SETTLE_W | Crystal-settle time in clock cycles |
| clk_ctrl | input | NBLK | Per-block clock-enable register value |
| wfi_req | input | 1 | CPU wait-for-interrupt request |
| cpu_irq | input | 1 | Interrupt that releases the CPU clock |
| state_o | output | 3 | Current power state code |
| rtc_en | output | 1 | RTC domain enable |
| main_pwr_en | output | 1 | Main power domain enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| blk_clk_en | output | NBLK | Per-block high-speed clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |

## Verification
The hardest situation to reach from the ports is a wake event in the very cycle that a sleep request is honoured. The Sleep or Deep-sleep state then lasts exactly one cycle, so it is easy to miss. A second hard case is a non-RTC wake arriving during Deep-sleep, which must be ignored.

Directed sequences set up both cases explicitly. They drive sleep_req together with each kind of wake, and they hold the MAC, host and external wakes high for several cycles in Deep-sleep.

A seeded random phase then drives dense, overlapping requests, wakes, settle values and short drops of the enable pin. It compares every cycle against a bench reference model of the state sequence, which reaches the coincident and interrupted cases many times over.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,
        PS_DEEP  = 3'd1,
        PS_SLEEP = 3'd2,
        PS_WAKE  = 3'd3,
        PS_ON    = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic rtc;
        logic main;
        logic xtal;
        logic pll;
    } rails_t;

    typedef struct packed {
        logic mac;
        logic host;
        logic rtc;
        logic ext;
    } wake_t;

    function automatic rails_t rails_for(pwr_state_e s);
        rails_t r;
        r = '0;
        unique case (s)
            PS_DEEP:  r = '{rtc: 1'b1, main: 1'b0, xtal: 1'b0, pll: 1'b0};
            PS_SLEEP: r = '{rtc: 1'b1, main: 1'b1, xtal: 1'b0, pll: 1'b0};
            PS_WAKE,
            PS_ON:    r = '{rtc: 1'b1, main: 1'b1, xtal: 1'b1, pll: 1'b1};
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic logic any_wake(wake_t w);
        return w.mac | w.host | w.rtc | w.ext;
    endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                sleep_req,
    input  logic                deep_sel,
    input  wake_t               wake,
    input  logic [SETTLE_W-1:0] settle_cfg,
    output pwr_state_e          state,
    output rails_t              rails
);
    localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

    pwr_state_e          nxt;
    logic [SETTLE_W-1:0] cnt;
    logic                pend;
    logic                to_low;

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF:   nxt = PS_WAKE;
                PS_WAKE:  if (cnt <= CNT_ONE) nxt = PS_ON;
                PS_ON:    if (sleep_req) nxt = deep_sel ? PS_DEEP : PS_SLEEP;
                PS_SLEEP: if (any_wake(wake) || pend) nxt = PS_WAKE;
                PS_DEEP:  if (wake.rtc || pend) nxt = PS_WAKE;
                default:  nxt = PS_OFF;
            endcase
        end
    end

    assign to_low = (state == PS_ON) && (nxt == PS_SLEEP || nxt == PS_DEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_OFF;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == PS_WAKE && state != PS_WAKE)
                cnt <= settle_cfg;
            else if (state == PS_WAKE && cnt != '0)
                cnt <= cnt - CNT_ONE;
            if (to_low)
                pend <= deep_sel ? wake.rtc : any_wake(wake);
            else
                pend <= 1'b0;
        end
    end

    assign rails = rails_for(state);

    // R1: a low synchronized enable forces Off on the next edge
    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == PS_OFF);

    // R3: On is only ever entered from Wakeup
    a_r3_on_from_wake: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ON && $past(state) != PS_ON) |-> $past(state) == PS_WAKE);

    // R7: Deep-sleep is only entered from On with deep_sel high
    a_r7_deep_entry: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DEEP && $past(state) != PS_DEEP) |-> ($past(state) == PS_ON && $past(deep_sel)));

    // R8: Sleep leaves only for Wakeup or Off
    a_r8_sleep_exit: assert property (@(posedge clk) disable iff (rst)
        state == PS_SLEEP |=> (state == PS_SLEEP || state == PS_WAKE || state == PS_OFF));

    // R9: after its first cycle, Deep-sleep holds unless an RTC wake arrives
    a_r9_deep_hold: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DEEP && $past(state) == PS_DEEP && !wake.rtc && en) |=> state == PS_DEEP);
endmodule

// File: rtl/pwr_seq_gate.sv
module pwr_seq_gate #(
    parameter int NBLK = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            is_on,
    input  logic [NBLK-1:0] clk_ctrl,
    input  logic            wfi_req,
    input  logic            cpu_irq,
    output logic [NBLK-1:0] blk_clk_en,
    output logic            cpu_clk_en
);
    logic cpu_gated;

    always_ff @(posedge clk) begin
        if (rst || !is_on) cpu_gated <= 1'b0;
        else if (cpu_irq)  cpu_gated <= 1'b0;
        else if (wfi_req)  cpu_gated <= 1'b1;
    end

    assign cpu_clk_en = is_on && !cpu_gated;

    genvar i;
    generate
        for (i = 0; i < NBLK; i++) begin : g_blk
            assign blk_clk_en[i] = is_on && clk_ctrl[i];
        end
    endgenerate

    // R5: an interrupt restores the CPU clock while On
    a_r5_irq_ungates: assert property (@(posedge clk) disable iff (rst)
        (is_on && cpu_irq) |=> (!is_on || cpu_clk_en));

    // R5: wait-for-interrupt without an interrupt stops the CPU clock
    a_r5_wfi_gates: assert property (@(posedge clk) disable iff (rst)
        (is_on && wfi_req && !cpu_irq) |=> !cpu_clk_en);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_W = 16,
    parameter int NBLK     = 8,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chip_en_pin,
    input  logic                sleep_req,
    input  logic                deep_sel,
    input  logic                wake_mac,
    input  logic                wake_host,
    input  logic                wake_rtc,
    input  logic                wake_ext,
    input  logic [SETTLE_W-1:0] settle_cfg,
    input  logic [NBLK-1:0]     clk_ctrl,
    input  logic                wfi_req,
    input  logic                cpu_irq,
    output logic [2:0]          state_o,
    output logic                rtc_en,
    output logic                main_pwr_en,
    output logic                xtal_en,
    output logic                pll_en,
    output logic [NBLK-1:0]     blk_clk_en,
    output logic                cpu_clk_en
);
    logic       en_s;
    wake_t      wake;
    pwr_state_e state;
    rails_t     rails;

    assign wake = '{mac: wake_mac, host: wake_host, rtc: wake_rtc, ext: wake_ext};

    pwr_seq_sync #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (chip_en_pin),
        .q   (en_s)
    );

    pwr_seq_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en_s),
        .sleep_req  (sleep_req),
        .deep_sel   (deep_sel),
        .wake       (wake),
        .settle_cfg (settle_cfg),
        .state      (state),
        .rails      (rails)
    );

    pwr_seq_gate #(.NBLK(NBLK)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .is_on      (state == PS_ON),
        .clk_ctrl   (clk_ctrl),
        .wfi_req    (wfi_req),
        .cpu_irq    (cpu_irq),
        .blk_clk_en (blk_clk_en),
        .cpu_clk_en (cpu_clk_en)
    );

    assign state_o     = state;
    assign rtc_en      = rails.rtc;
    assign main_pwr_en = rails.main;
    assign xtal_en     = rails.xtal;
    assign pll_en      = rails.pll;

    // R4: no block clock runs unless the sequencer is On
    a_r4_blk_only_on: assert property (@(posedge clk) disable iff (rst)
        (blk_clk_en != '0) |-> (state_o == 3'd4 && xtal_en && pll_en));

    // R1: a pin low for the whole synchronizer depth forces Off
    a_r1_pin_low_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(chip_en_pin) && !$past(chip_en_pin, 2) && $past(rst, 2) == 1'b0) |=> state_o == 3'd0);
endmodule

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;
    localparam int NBLK = 8;
    localparam int SW   = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic            pin, slp, dsel, wmac, whost, wrtc, wext, wfi, irq;
    logic [SW-1:0]   settle;
    logic [NBLK-1:0] ctrl;
    logic [2:0]      state_o;
    logic            rtc_en, main_pwr_en, xtal_en, pll_en, cpu_clk_en;
    logic [NBLK-1:0] blk_clk_en;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pwr_seq_top #(.SETTLE_W(SW), .NBLK(NBLK)) u_dut (
        .clk(clk), .rst(rst), .chip_en_pin(pin), .sleep_req(slp), .deep_sel(dsel),
        .wake_mac(wmac), .wake_host(whost), .wake_rtc(wrtc), .wake_ext(wext),
        .settle_cfg(settle), .clk_ctrl(ctrl), .wfi_req(wfi), .cpu_irq(irq),
        .state_o(state_o), .rtc_en(rtc_en), .main_pwr_en(main_pwr_en),
        .xtal_en(xtal_en), .pll_en(pll_en), .blk_clk_en(blk_clk_en), .cpu_clk_en(cpu_clk_en)
    );

    // reference model built from the requirements
    logic          m_s1, m_s2, m_pend, m_gated;
    int            m_st;
    logic [SW-1:0] m_cnt;

    always @(posedge clk) begin
        int  nx;
        logic aw;
        aw = wmac | whost | wrtc | wext;
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_st <= 0; m_cnt <= 0; m_pend <= 0; m_gated <= 0;
        end else begin
            m_s1 <= pin;
            m_s2 <= m_s1;
            nx = m_st;
            if (!m_s2) nx = 0;
            else case (m_st)
                0: nx = 3;
                3: if (m_cnt <= 1) nx = 4;
                4: if (slp) nx = dsel ? 1 : 2;
                2: if (aw || m_pend) nx = 3;
                1: if (wrtc || m_pend) nx = 3;
                default: nx = 0;
            endcase
            if (nx == 3 && m_st != 3) m_cnt <= settle;
            else if (m_st == 3 && m_cnt != 0) m_cnt <= m_cnt - 1;
            m_pend <= (m_st == 4 && (nx == 1 || nx == 2)) ? (dsel ? wrtc : aw) : 1'b0;
            if (m_st != 4 || irq) m_gated <= 0;
            else if (wfi) m_gated <= 1;
            m_st <= nx;
        end
    end

    function automatic logic [15:0] exp_vec(int st, logic g, logic [NBLK-1:0] c);
        logic [3:0] r;
        case (st)
            1: r = 4'b1000;
            2: r = 4'b1100;
            3, 4: r = 4'b1111;
            default: r = 4'b0000;
        endcase
        return {3'(st), r, (st == 4) ? c : {NBLK{1'b0}}, (st == 4) && !g};
    endfunction

    function automatic logic [15:0] dut_vec();
        return {state_o, rtc_en, main_pwr_en, xtal_en, pll_en, blk_clk_en, cpu_clk_en};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input int st, input logic g);
        logic [15:0] e;
        e = exp_vec(st, g, ctrl);
        chk(dut_vec() === e, req, dut_vec(), e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_wake();
        wmac = 0; whost = 0; wrtc = 0; wext = 0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 16'd0, 16'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; pin = 0; slp = 0; dsel = 0; wfi = 0; irq = 0; clr_wake();
        settle = 16'd3; ctrl = 8'hA5;
        tick(3);
        rst = 0;
        tick(1);
        chk_vec("R1 reset/off", 0, 0);
        chk(state_o == 3'd0, "R11 off code", {13'd0, state_o}, 16'd0);

        pin = 1;
        tick(2);
        chk_vec("R2 still off", 0, 0);
        tick(1);
        chk_vec("R2 wakeup after sync", 3, 0);
        tick(2);
        chk_vec("R3 settle hold", 3, 0);
        tick(1);
        chk_vec("R3 R4 on after settle", 4, 0);

        wfi = 1; tick(1); wfi = 0;
        chk_vec("R5 wfi gates cpu", 4, 1);
        wfi = 1; irq = 1; tick(1); wfi = 0; irq = 0;
        chk_vec("R5 irq priority", 4, 0);

        settle = 16'd0;
        slp = 1; dsel = 0; tick(1); slp = 0;
        chk_vec("R6 sleep rails", 2, 0);
        tick(3);
        chk_vec("R8 sleep holds", 2, 0);
        whost = 1; tick(1); clr_wake();
        chk_vec("R8 host wake", 3, 0);
        tick(1);
        chk_vec("R3 zero settle one cycle", 4, 0);

        slp = 1; dsel = 1; tick(1); slp = 0;
        chk_vec("R7 deep rails", 1, 0);
        wmac = 1; whost = 1; wext = 1; tick(3); clr_wake();
        chk_vec("R9 non-rtc ignored", 1, 0);
        wrtc = 1; tick(1); clr_wake();
        chk_vec("R9 rtc wake", 3, 0);
        tick(1);
        chk_vec("R9 back on", 4, 0);

        slp = 1; dsel = 0; wext = 1; tick(1); slp = 0; clr_wake();
        chk_vec("R10 one sleep cycle", 2, 0);
        tick(1);
        chk_vec("R10 wake kept", 3, 0);
        tick(1);
        slp = 1; dsel = 1; wrtc = 1; tick(1); slp = 0; clr_wake();
        chk_vec("R10 one deep cycle", 1, 0);
        tick(1);
        chk_vec("R10 deep wake kept", 3, 0);
        tick(1);
        chk_vec("R4 on", 4, 0);

        pin = 0;
        tick(2);
        chk_vec("R1 on during sync", 4, 0);
        tick(1);
        chk_vec("R1 off after disable", 0, 0);
        pin = 1;

        for (int k = 0; k < 4000; k++) begin
            pin    = ($urandom % 150) != 0;
            slp    = ($urandom % 6) == 0;
            dsel   = $urandom % 2;
            wmac   = ($urandom % 12) == 0;
            whost  = ($urandom % 12) == 0;
            wrtc   = ($urandom % 12) == 0;
            wext   = ($urandom % 12) == 0;
            wfi    = ($urandom % 5) == 0;
            irq    = ($urandom % 7) == 0;
            settle = SW'($urandom % 7);
            ctrl   = NBLK'($urandom);
            tick(1);
            chk_vec("R1-model random (R3 R4 R5 R6 R7 R8 R9 R10)", m_st, m_gated);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule